// File: doc/BRIEF.md
# Dual-Direction Storing Bus Transceiver

This block joins two bidirectional 18-bit buses, A and B. Each direction owns a storage path that can run in three ways. It can be transparent, so the output follows the input with no register delay. It can hold, keeping a stored word. It can also capture on a rising edge of its own capture strobe. The A-to-B and B-to-A paths use independent control sets. Each set has an active-low output enable, a transparent enable, a capture strobe and an active-low strobe qualifier.

All state is clocked by one system clock `clk`. Each capture strobe is sampled by `clk`, and a low-to-high change between two samples counts as a capture edge. Each path drives its data and a drive enable internally, and the top level turns them into tri-state pins. The block has no data handshake: it is a pin-level transceiver, so every port is a plain control or bus pin.

Top module: `bus_xcvr18`

## Requirements
- R1: While `ab_pass` is 1 and `ab_oe_n` is 0, `port_b` equals `port_a` in the same cycle, with no clock edge needed.
- R2: While the transparent enable of a path is 0 and its strobe keeps one level (high or low) across `clk` edges, the path's output keeps its stored word. After the transparent enable falls, the stored word is the input seen at the last `clk` edge taken while the enable was 1.
- R3: With the transparent enable at 0 and the strobe qualifier at 0, a strobe that is 0 at one `clk` edge and 1 at the next loads the input present at that second edge. The new word appears on the output right after that edge, and not before it.
- R4: The strobe qualifier is active low. While it is 1, a rising strobe leaves the stored word unchanged.
- R5: The output enable is active low. While `ab_oe_n` is 1, `port_b` is high impedance, and while `ba_oe_n` is 1, `port_a` is high impedance.
- R6: A path still loads while its output is disabled. Enabling the output then presents the loaded word.
- R7: The B-to-A path obeys R1 to R6 through `ba_oe_n`, `ba_pass`, `ba_strobe` and `ba_strobe_en_n`, independently of the A-to-B path.
- R8: Synchronous reset `rst` clears both stored words to zero. It also makes each strobe count as high, so a strobe that is high when reset ends causes no capture until it has been seen low.
- R9: Both data paths are `W` bits wide, with 18 as the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for all storage |
| rst | input | 1 | Synchronous reset, active high |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_pass | input | 1 | A-to-B transparent enable |
| ab_strobe | input | 1 | A-to-B capture strobe, sampled by clk |
| ab_strobe_en_n | input | 1 | A-to-B strobe qualifier, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A transparent enable |
| ba_strobe | input | 1 | B-to-A capture strobe, sampled by clk |
| ba_strobe_en_n | input | 1 | B-to-A strobe qualifier, active low |
| port_a | inout | W | Bus A, input to A-to-B, driven by B-to-A |
| port_b | inout | W | Bus B, input to B-to-A, driven by A-to-B |

## Verification
A wrong stored word stays hidden during transparent operation. It appears on the far bus in the same cycle the transparent enable drops, and the bench checks at exactly that point. A spurious or missed capture edge shows as a wrong word one `clk` edge after the strobe change. The bench therefore checks both just before and just after that edge. A drive enable stuck on shows at once as a driven value where high impedance is expected.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  // R8: reset treats the strobe as already high
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pass,
  input  logic         strobe,
  input  logic         strobe_en_n,
  input  logic         oe_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive_en,
  output logic [W-1:0] held
);
  logic         edge_seen;
  logic         load;
  logic [W-1:0] held_q;

  xcvr_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (strobe),
    .rise (edge_seen)
  );

  assign load = pass | (edge_seen & ~strobe_en_n);

  always_ff @(posedge clk) begin
    if (rst)       held_q <= '0;
    else if (load) held_q <= din;
  end

  // transparent bypass: a mux, so no latch is inferred
  assign dout     = pass ? din : held_q;
  assign drive_en = ~oe_n;
  assign held     = held_q;
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18 #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ab_oe_n,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ab_strobe_en_n,
  input  logic         ba_oe_n,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  input  logic         ba_strobe_en_n,
  inout  wire  [W-1:0] port_a,
  inout  wire  [W-1:0] port_b
);
  import xcvr_pkg::*;

  logic [NUM_DIR-1:0]        pass_v;
  logic [NUM_DIR-1:0]        strobe_v;
  logic [NUM_DIR-1:0]        sen_v;
  logic [NUM_DIR-1:0]        oe_v;
  logic [NUM_DIR-1:0]        drv_v;
  logic [NUM_DIR-1:0][W-1:0] din_v;
  logic [NUM_DIR-1:0][W-1:0] dout_v;
  logic [NUM_DIR-1:0][W-1:0] held_v;

  assign pass_v[DIR_AB]   = ab_pass;
  assign pass_v[DIR_BA]   = ba_pass;
  assign strobe_v[DIR_AB] = ab_strobe;
  assign strobe_v[DIR_BA] = ba_strobe;
  assign sen_v[DIR_AB]    = ab_strobe_en_n;
  assign sen_v[DIR_BA]    = ba_strobe_en_n;
  assign oe_v[DIR_AB]     = ab_oe_n;
  assign oe_v[DIR_BA]     = ba_oe_n;
  assign din_v[DIR_AB]    = port_a;
  assign din_v[DIR_BA]    = port_b;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk         (clk),
      .rst         (rst),
      .pass        (pass_v[d]),
      .strobe      (strobe_v[d]),
      .strobe_en_n (sen_v[d]),
      .oe_n        (oe_v[d]),
      .din         (din_v[d]),
      .dout        (dout_v[d]),
      .drive_en    (drv_v[d]),
      .held        (held_v[d])
    );
  end

  // R5: pin resolution of each path's data and drive enable
  assign port_b = drv_v[DIR_AB] ? dout_v[DIR_AB] : {W{1'bz}};
  assign port_a = drv_v[DIR_BA] ? dout_v[DIR_BA] : {W{1'bz}};
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       pass_v,
  input logic [1:0]       strobe_v,
  input logic [1:0]       sen_v,
  input logic [1:0]       oe_v,
  input logic [1:0][W-1:0] din_v,
  input logic [1:0][W-1:0] held_v,
  input logic [W-1:0]     port_a,
  input logic [W-1:0]     port_b
);
  logic armed;
  always_ff @(posedge clk) armed <= ~rst;

  for (genvar d = 0; d < 2; d++) begin : g_chk
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!pass_v[d] && $stable(strobe_v[d])) |=> $stable(held_v[d]));
    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
      (armed && !pass_v[d] && $rose(strobe_v[d]) && !sen_v[d])
        |=> (held_v[d] == $past(din_v[d])));
    // R4
    gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!pass_v[d] && sen_v[d]) |=> $stable(held_v[d]));
    // R8
    reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (held_v[d] == '0));
  end

  // R1
  pass_ab_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_v[0] && !oe_v[0] && oe_v[1]) |-> (port_b === port_a));
  // R7
  pass_ba_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_v[1] && !oe_v[1] && oe_v[0]) |-> (port_a === port_b));
endmodule

bind bus_xcvr18 xcvr_chk #(.W(W)) u_xcvr_chk (
  .clk      (clk),
  .rst      (rst),
  .pass_v   (pass_v),
  .strobe_v (strobe_v),
  .sen_v    (sen_v),
  .oe_v     (oe_v),
  .din_v    (din_v),
  .held_v   (held_v),
  .port_a   (port_a),
  .port_b   (port_b)
);

// File: tb/test_bus_xcvr18.sv
module test_bus_xcvr18;
  localparam int W     = 18;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] oe_n  = 2'b11;
  logic [1:0] pass  = 2'b00;
  logic [1:0] stb   = 2'b11;
  logic [1:0] sen_n = 2'b00;
  logic [W-1:0] tb_a = '0;
  logic [W-1:0] tb_b = '0;
  logic tb_a_en = 1'b1;
  logic tb_b_en = 1'b1;
  wire  [W-1:0] port_a;
  wire  [W-1:0] port_b;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign port_a = tb_a_en ? tb_a : {W{1'bz}};
  assign port_b = tb_b_en ? tb_b : {W{1'bz}};

  bus_xcvr18 #(.W(W)) i_bus_xcvr18 (
    .clk(clk), .rst(rst),
    .ab_oe_n(oe_n[0]), .ab_pass(pass[0]), .ab_strobe(stb[0]), .ab_strobe_en_n(sen_n[0]),
    .ba_oe_n(oe_n[1]), .ba_pass(pass[1]), .ba_strobe(stb[1]), .ba_strobe_en_n(sen_n[1]),
    .port_a(port_a), .port_b(port_b)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(input int dir, input string r);
    return (dir == 1) ? {r, "/R7"} : r;
  endfunction

  task automatic set_src(input int dir, input logic [W-1:0] v);
    if (dir == 0) tb_a = v; else tb_b = v;
  endtask

  function automatic logic [W-1:0] dst(input int dir);
    return (dir == 0) ? port_b : port_a;
  endfunction

  task automatic setup(input int dir);
    oe_n[dir]   = 1'b0;
    oe_n[1-dir] = 1'b1;
    sen_n[dir]  = 1'b0;
    tb_a_en     = (dir == 0);
    tb_b_en     = (dir == 1);
  endtask

  task automatic t_reset();
    rst = 1'b1; stb = 2'b11;
    step(); step();
    rst = 1'b0;
    setup(0); set_src(0, 18'h2AAAA);
    #1 check(port_b, '0, "R8 cleared after reset");
    step();
    check(port_b, '0, "R8 high strobe after reset no capture");
    stb[0] = 1'b0; step();
    stb[0] = 1'b1; step();
    check(port_b, 18'h2AAAA, "R8 capture after strobe seen low");
  endtask

  task automatic t_transparent(input int dir);
    logic [W-1:0] pats [4] = '{18'h00000, 18'h3FFFF, 18'h15555, 18'h0F0F3};
    setup(dir); pass[dir] = 1'b1;
    foreach (pats[i]) begin
      set_src(dir, pats[i]);
      #1 check(dst(dir), pats[i], tag(dir, "R1 transparent"));
    end
    step();
    check(dst(dir), pats[3], tag(dir, "R1 transparent after edge"));
  endtask

  task automatic t_hold(input int dir);
    setup(dir); pass[dir] = 1'b1; stb[dir] = 1'b0;
    set_src(dir, 18'h1234A); step();
    pass[dir] = 1'b0; set_src(dir, 18'h0BEEF);
    #1 check(dst(dir), 18'h1234A, tag(dir, "R2 hold on pass fall"));
    step(); step();
    check(dst(dir), 18'h1234A, tag(dir, "R2 hold strobe low"));
  endtask

  task automatic t_clocked(input int dir);
    setup(dir); pass[dir] = 1'b0; stb[dir] = 1'b0;
    set_src(dir, 18'h3C3C3); step();
    check(dst(dir), 18'h1234A, tag(dir, "R2 hold before capture"));
    stb[dir] = 1'b1;
    #1 check(dst(dir), 18'h1234A, tag(dir, "R3 no change before edge"));
    step();
    check(dst(dir), 18'h3C3C3, tag(dir, "R3 captured on rising strobe"));
    set_src(dir, 18'h00F0F); step(); step();
    check(dst(dir), 18'h3C3C3, tag(dir, "R2 hold strobe high"));
  endtask

  task automatic t_gated(input int dir);
    setup(dir); sen_n[dir] = 1'b1; stb[dir] = 1'b0;
    set_src(dir, 18'h2DB6D); step();
    stb[dir] = 1'b1; step();
    check(dst(dir), 18'h3C3C3, tag(dir, "R4 gated strobe ignored"));
    sen_n[dir] = 1'b0; stb[dir] = 1'b0; step();
    stb[dir] = 1'b1; step();
    check(dst(dir), 18'h2DB6D, tag(dir, "R4 enabled strobe captures"));
  endtask

  task automatic t_oe(input int dir);
    setup(dir); oe_n[dir] = 1'b1;
    #1 check(dst(dir), {W{1'bz}}, tag(dir, "R5 high impedance"));
    stb[dir] = 1'b0; set_src(dir, 18'h0C0DE); step();
    stb[dir] = 1'b1; step();
    check(dst(dir), {W{1'bz}}, tag(dir, "R5 still high impedance"));
    oe_n[dir] = 1'b0;
    #1 check(dst(dir), 18'h0C0DE, tag(dir, "R6 loaded while disabled"));
    oe_n[dir] = 1'b1; step();
  endtask

  initial begin
    t_reset();
    for (int d = 0; d < 2; d++) begin
      t_transparent(d);
      t_hold(d);
      t_clocked(d);
      t_gated(d);
      t_oe(d);
    end
    // R9: all checks above use full 18-bit patterns
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule